// File: doc/BRIEF.md
# Pulsed RF Overpower Trip Monitor

This block guards a pulsed RF station. It watches eight digitized RF power levels while the RF gate is open, along with fourteen arc detector inputs, a software interlock request and a vacuum-OK line. When any enabled condition fails, it latches a fast shutdown trip. The trip is driven on two independent flops so that the drive controller receives it on redundant lines.

Each power channel has its own threshold and its own time limit. A channel does not trip on a single sample over its threshold. It trips only when the level stays above the threshold for more consecutive gated cycles than its limit allows. The vacuum-OK input has no enable and always trips when it is low. A first-fault register records every source that was active on the edge that set the trip. The trip and this register stay latched until a clear is applied.

Top module: `rf_trip_monitor`

## Requirements
- R1: After reset, `trip_a_o` and `trip_b_o` are low and `first_src_o` is zero.
- R2: A channel whose level is strictly above its threshold on L+1 consecutive gated cycles, where L is its `limit_i` value, trips on the edge that samples the (L+1)th such cycle. L such cycles alone do not trip; a limit of 0 trips on the first over-threshold cycle.
- R3: A channel's over-threshold run restarts when its level is equal to or below its threshold, or when the gate is low.
- R4: While `gate_i` is low, power levels cause no trip.
- R5: A channel whose `ch_en_i` bit is 0 causes no trip.
- R6: An arc input that is high with its `arc_en_i` bit set trips on the next edge, whether or not the gate is open. A masked arc input causes no trip.
- R7: `sw_req_i` trips on the next edge when `sw_en_i` is 1, and has no effect when `sw_en_i` is 0.
- R8: `vac_ok_i` low trips on the next edge, whatever the enables are.
- R9: `trip_a_o` and `trip_b_o` always carry the same value.
- R10: The trip stays set until `clear_i` is high at an edge. Clear wins over a fault on the same edge, and a fault that persists trips again on the following edge.
- R11: `first_src_o` captures all faulting sources on the edge that sets the trip, and holds that value while the trip stays latched. Bit layout: [7:0] channel n at bit n, [21:8] arc input n at bit 8+n, [22] software request, [23] vacuum.
- R12: Trip outputs are registered: a qualifying condition sampled at one edge shows at the outputs right after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_i | input | 1 | RF gate; power channels are evaluated only while it is high |
| level_i | input | 96 | Eight 12-bit power levels; channel n at bits [12n+11:12n] |
| thresh_i | input | 96 | Eight 12-bit thresholds, same packing as the levels |
| limit_i | input | 128 | Eight 16-bit time limits in cycles; channel n at bits [16n+15:16n] |
| ch_en_i | input | 8 | Per-channel trip enable |
| arc_i | input | 14 | Arc detector inputs, active high |
| arc_en_i | input | 14 | Per-arc trip enable |
| sw_req_i | input | 1 | Software or computed interlock request |
| sw_en_i | input | 1 | Enable for the software request |
| vac_ok_i | input | 1 | Vacuum good; low always trips |
| clear_i | input | 1 | Synchronous clear of the trip and the first-fault register |
| trip_a_o | output | 1 | Trip line A |
| trip_b_o | output | 1 | Trip line B, redundant copy |
| first_src_o | output | 24 | Sources active when the trip was set |

## Verification
The assertions check the following on every cycle: the two trip lines agree, a latched trip holds until clear, clear forces the trip low, and an arc, software request or vacuum fault trips on the next edge. They also check that the first-fault register is non-zero on a rising trip and stays stable while the trip is latched. The exact duration rule of each channel needs the bench's directed scenarios. These cover the L-versus-L+1 boundary, a level equal to the threshold, a run broken by a low sample or by a closed gate, and a zero limit. The bench also shows which bits the first-fault register holds when several sources fault together.

// File: rtl/rf_trip_pkg.sv
package rf_trip_pkg;
  localparam int unsigned DEF_NCH  = 8;
  localparam int unsigned DEF_NARC = 14;
  localparam int unsigned DEF_LW   = 12;
  localparam int unsigned DEF_CW   = 16;
endpackage

// File: rtl/rf_chan_timer.sv
module rf_chan_timer #(
  parameter int unsigned LW = 12,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gate_i,
  input  logic          en_i,
  input  logic [LW-1:0] level_i,
  input  logic [LW-1:0] thresh_i,
  input  logic [CW-1:0] limit_i,
  output logic          fault_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic          over;
  logic [CW-1:0] run_q;

  assign over = gate_i && (level_i > thresh_i);

  // run_q counts prior consecutive over-threshold cycles, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              run_q <= '0;
    else if (!over)           run_q <= '0;
    else if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
  end

  assign fault_o = en_i && over && (run_q >= limit_i);
endmodule

// File: rtl/rf_trip_latch.sv
module rf_trip_latch #(
  parameter int unsigned NSRC = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] fault_i,
  input  logic            clear_i,
  output logic            trip_a_o,
  output logic            trip_b_o,
  output logic [NSRC-1:0] src_o
);
  logic            trip_a_q, trip_b_q;
  logic [NSRC-1:0] src_q;
  logic            any_fault;

  assign any_fault = |fault_i;

  // two independent flops drive the redundant lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_a_q <= 1'b0;
      trip_b_q <= 1'b0;
    end else if (clear_i) begin
      trip_a_q <= 1'b0;
      trip_b_q <= 1'b0;
    end else if (any_fault) begin
      trip_a_q <= 1'b1;
      trip_b_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      src_q <= '0;
    else if (clear_i)                 src_q <= '0;
    else if (!trip_a_q && any_fault)  src_q <= fault_i;
  end

  assign trip_a_o = trip_a_q;
  assign trip_b_o = trip_b_q;
  assign src_o    = src_q;
endmodule

// File: rtl/rf_trip_monitor.sv
module rf_trip_monitor
  import rf_trip_pkg::*;
#(
  parameter int unsigned NCH  = DEF_NCH,
  parameter int unsigned NARC = DEF_NARC,
  parameter int unsigned LW   = DEF_LW,
  parameter int unsigned CW   = DEF_CW,
  localparam int unsigned NSRC = NCH + NARC + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_i,
  input  logic [NCH*LW-1:0] level_i,
  input  logic [NCH*LW-1:0] thresh_i,
  input  logic [NCH*CW-1:0] limit_i,
  input  logic [NCH-1:0]    ch_en_i,
  input  logic [NARC-1:0]   arc_i,
  input  logic [NARC-1:0]   arc_en_i,
  input  logic              sw_req_i,
  input  logic              sw_en_i,
  input  logic              vac_ok_i,
  input  logic              clear_i,
  output logic              trip_a_o,
  output logic              trip_b_o,
  output logic [NSRC-1:0]   first_src_o
);
  localparam int unsigned SRC_ARC = NCH;
  localparam int unsigned SRC_SW  = NCH + NARC;
  localparam int unsigned SRC_VAC = NCH + NARC + 1;

  logic [NCH-1:0]  ch_fault;
  logic [NSRC-1:0] fault;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    rf_chan_timer #(.LW(LW), .CW(CW)) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .gate_i   (gate_i),
      .en_i     (ch_en_i[c]),
      .level_i  (level_i[c*LW +: LW]),
      .thresh_i (thresh_i[c*LW +: LW]),
      .limit_i  (limit_i[c*CW +: CW]),
      .fault_o  (ch_fault[c])
    );
  end

  always_comb begin
    fault                     = '0;
    fault[NCH-1:0]            = ch_fault;
    fault[SRC_ARC +: NARC]    = arc_i & arc_en_i;
    fault[SRC_SW]             = sw_req_i & sw_en_i;
    fault[SRC_VAC]            = ~vac_ok_i;  // no mask by design
  end

  rf_trip_latch #(.NSRC(NSRC)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fault_i  (fault),
    .clear_i  (clear_i),
    .trip_a_o (trip_a_o),
    .trip_b_o (trip_b_o),
    .src_o    (first_src_o)
  );
endmodule

// File: rtl/rf_trip_monitor_chk.sv
module rf_trip_monitor_chk #(
  parameter int unsigned NARC = 14,
  parameter int unsigned NSRC = 24
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NARC-1:0] arc_i,
  input logic [NARC-1:0] arc_en_i,
  input logic            sw_req_i,
  input logic            sw_en_i,
  input logic            vac_ok_i,
  input logic            clear_i,
  input logic            trip_a_o,
  input logic            trip_b_o,
  input logic [NSRC-1:0] first_src_o
);
  assert_dual_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_a_o == trip_b_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_a_o && !clear_i) |=> trip_a_o);

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!trip_a_o && first_src_o == '0));

  assert_vac_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vac_ok_i && !clear_i) |=> trip_a_o);

  assert_arc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(arc_i & arc_en_i)) && !clear_i) |=> trip_a_o);

  assert_sw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_req_i && sw_en_i && !clear_i) |=> trip_a_o);

  assert_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_a_o) |-> (first_src_o != '0));

  assert_src_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_a_o && !clear_i) |=> $stable(first_src_o));
endmodule

bind rf_trip_monitor rf_trip_monitor_chk #(.NARC(NARC), .NSRC(NSRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .arc_i       (arc_i),
  .arc_en_i    (arc_en_i),
  .sw_req_i    (sw_req_i),
  .sw_en_i     (sw_en_i),
  .vac_ok_i    (vac_ok_i),
  .clear_i     (clear_i),
  .trip_a_o    (trip_a_o),
  .trip_b_o    (trip_b_o),
  .first_src_o (first_src_o)
);

// File: tb/tb_rf_trip_monitor.sv
`timescale 1ns/100ps
module tb_rf_trip_monitor;
  localparam int NCH = 8, NARC = 14, LW = 12, CW = 16, NSRC = 24;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              gate_i = 1'b0;
  logic [NCH*LW-1:0] level_i = '0;
  logic [NCH*LW-1:0] thresh_i = '0;
  logic [NCH*CW-1:0] limit_i = '0;
  logic [NCH-1:0]    ch_en_i = '1;
  logic [NARC-1:0]   arc_i = '0;
  logic [NARC-1:0]   arc_en_i = '1;
  logic              sw_req_i = 1'b0;
  logic              sw_en_i = 1'b1;
  logic              vac_ok_i = 1'b1;
  logic              clear_i = 1'b0;
  logic              trip_a_o, trip_b_o;
  logic [NSRC-1:0]   first_src_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  rf_trip_monitor dut (.*);

  typedef struct packed {
    logic [13:0] arc;
    logic [13:0] arc_en;
    logic        sw;
    logic        sw_en;
    logic        vac;
    logic        exp_trip;
    logic [23:0] exp_src;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{14'h0000, 14'h3fff, 1'b0, 1'b1, 1'b1, 1'b0, 24'h000000},
    '{14'h0008, 14'h3fff, 1'b0, 1'b1, 1'b1, 1'b1, 24'h000800},
    '{14'h0008, 14'h3ff7, 1'b0, 1'b1, 1'b1, 1'b0, 24'h000000},
    '{14'h2000, 14'h3fff, 1'b0, 1'b1, 1'b1, 1'b1, 24'h200000},
    '{14'h0000, 14'h3fff, 1'b1, 1'b1, 1'b1, 1'b1, 24'h400000},
    '{14'h0000, 14'h3fff, 1'b1, 1'b0, 1'b1, 1'b0, 24'h000000},
    '{14'h0000, 14'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 24'h800000},
    '{14'h0021, 14'h0020, 1'b1, 1'b1, 1'b1, 1'b1, 24'h402000}
  };

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic check(string req, logic exp_trip, logic [23:0] exp_src);
    checks++;
    if (trip_a_o !== exp_trip || trip_b_o !== exp_trip || first_src_o !== exp_src) begin
      errors++;
      $display("FAIL %s: trip_a=%b trip_b=%b src=%h, expected trip=%b src=%h",
               req, trip_a_o, trip_b_o, first_src_o, exp_trip, exp_src);
    end
  endtask

  task automatic set_ch(int c, int lvl, int lim);
    level_i[c*LW +: LW] = LW'(lvl);
    limit_i[c*CW +: CW] = CW'(lim);
  endtask

  task automatic do_clear();
    gate_i = 1'b0; level_i = '0; arc_i = '0; sw_req_i = 1'b0; vac_ok_i = 1'b1;
    ch_en_i = '1; arc_en_i = '1; sw_en_i = 1'b1;
    clear_i = 1'b1;
    step();
    clear_i = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) thresh_i[c*LW +: LW] = LW'(100);
    #1;
    check("R1 in reset", 1'b0, 24'h0);
    step(2);
    rst_ni = 1'b1;
    step();
    check("R1 after reset", 1'b0, 24'h0);

    // table: arc, software, vacuum sources with gate closed
    foreach (VECS[i]) begin
      do_clear();
      arc_i = VECS[i].arc; arc_en_i = VECS[i].arc_en;
      sw_req_i = VECS[i].sw; sw_en_i = VECS[i].sw_en; vac_ok_i = VECS[i].vac;
      step();
      check($sformatf("R6 R7 R8 R11 R12 vector %0d", i), VECS[i].exp_trip, VECS[i].exp_src);
    end

    // R2 R12: limit 5, boundary at 5 vs 6 cycles
    do_clear();
    set_ch(2, 101, 5); gate_i = 1'b1;
    step(5);
    check("R2 L cycles no trip", 1'b0, 24'h0);
    step();
    check("R2 L+1 cycles trip", 1'b1, 24'h000004);

    // R2: zero limit
    do_clear();
    set_ch(0, 101, 0); gate_i = 1'b1;
    step();
    check("R2 zero limit", 1'b1, 24'h000001);

    // R3: equal to threshold is not over
    do_clear();
    set_ch(1, 100, 0); gate_i = 1'b1;
    step(3);
    check("R3 equal level", 1'b0, 24'h0);

    // R3: low sample restarts run
    do_clear();
    set_ch(3, 101, 4); gate_i = 1'b1;
    step(4);
    set_ch(3, 100, 4); step();
    set_ch(3, 101, 4); step(4);
    check("R3 run restarted by low level", 1'b0, 24'h0);
    step();
    check("R3 trip after full new run", 1'b1, 24'h000008);

    // R3 R4: gate drop restarts run
    do_clear();
    set_ch(4, 101, 3); gate_i = 1'b1;
    step(3);
    gate_i = 1'b0; step();
    gate_i = 1'b1; step(3);
    check("R3 run restarted by gate", 1'b0, 24'h0);
    step();
    check("R3 trip after gate restart", 1'b1, 24'h000010);

    // R4: gate low ignores levels
    do_clear();
    set_ch(5, 4000, 0);
    step(10);
    check("R4 gate low", 1'b0, 24'h0);

    // R5: channel mask
    do_clear();
    set_ch(6, 200, 0); ch_en_i[6] = 1'b0; gate_i = 1'b1;
    step(5);
    check("R5 masked channel", 1'b0, 24'h0);
    ch_en_i[6] = 1'b1; step();
    check("R5 enabled channel", 1'b1, 24'h000040);

    // R10 R11: hold, clear priority, re-trip
    do_clear();
    arc_i[0] = 1'b1; step();
    check("R11 first arc", 1'b1, 24'h000100);
    sw_req_i = 1'b1; step(2);
    check("R11 source held", 1'b1, 24'h000100);
    arc_i[0] = 1'b0; sw_req_i = 1'b0; step(3);
    check("R10 latched after fault gone", 1'b1, 24'h000100);
    arc_i[0] = 1'b1; sw_req_i = 1'b1; clear_i = 1'b1; step();
    check("R10 clear wins", 1'b0, 24'h0);
    clear_i = 1'b0; step();
    check("R10 R11 re-trip both sources", 1'b1, 24'h400100);

    do_clear();
    check("R10 cleared", 1'b0, 24'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule